// File: doc/BRIEF.md
# ALU Status and Control Flag Register

This block turns one ALU operation into status flags and keeps them, together with three control flags, in a 16-bit flag word. The ALU sends operand A, operand B, the result it produced, its carry (or borrow) out, an operation class and a byte/word select. When the update enable is high, the six status flags are worked out for the selected width and stored at the next clock edge. Three pairs of set/clear strobes control the direction, interrupt-enable and trap flags on their own, whether or not a status update happens in the same cycle.

The block also gives the signed step that string operations add to their pointers. It is +1 or +2 when the direction flag is clear and -1 or -2 when it is set. The size of the step follows the byte/word select.

Top module: `alu_flag_unit`

## Requirements
- R1: After a synchronous reset, `flags_q` reads 16'hF002: all status and control flags are 0.
- R2: Bits 15:12 and bit 1 of `flags_q` always read 1. Bits 3 and 5 always read 0.
- R3: The status flags change only in the cycle after `upd_en` is high. With `upd_en` low and no control strobe, `flags_q` keeps its value.
- R4: ZF (bit 6) is 1 when the result is zero over the selected width. SF (bit 7) copies the top bit of that width: bit 7 when `word_sel`=0, bit 15 when `word_sel`=1.
- R5: PF (bit 2) is 1 when `alu_res[7:0]` holds an even number of ones. This holds for word operations too; the upper byte is not looked at.
- R6: For add (`op_class`=0) and subtract (`op_class`=1), AF (bit 4) records a carry or borrow across the bit 3 to bit 4 boundary, which is `opnd_a[4]^opnd_b[4]^alu_res[4]`.
- R7: For add and subtract, CF (bit 0) takes the value of `alu_cout`. That input is the carry out of, or the borrow into, the top bit of the selected width.
- R8: For add, OF (bit 11) is set when both operands have the same top bit and the result's top bit differs from it. For subtract (A minus B), OF is set when the operands' top bits differ and the result's top bit differs from A's.
- R9: For the logic class (`op_class`=2 or 3), CF and OF are cleared, AF keeps its old value, and SF, ZF and PF update as in R4 and R5.
- R10: Control flags DF (bit 10), IF (bit 9) and TF (bit 8) are set by their set strobe and cleared by their clear strobe one cycle later. If both strobes are high, set wins. A status update never changes them.
- R11: `str_step` is +1 (byte) or +2 (word) when the stored DF is 0, and -1 or -2 in two's complement when DF is 1. It follows `word_sel` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Store the status flags of this operation |
| op_class | input | 2 | 0 add, 1 subtract, 2/3 logic |
| word_sel | input | 1 | 1 word (16-bit), 0 byte (low 8 bits) |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| alu_res | input | 16 | Result from the ALU |
| alu_cout | input | 1 | Carry/borrow out of the top bit of the selected width |
| df_set | input | 1 | Set direction flag |
| df_clr | input | 1 | Clear direction flag |
| if_set | input | 1 | Set interrupt-enable flag |
| if_clr | input | 1 | Clear interrupt-enable flag |
| tf_set | input | 1 | Set trap flag |
| tf_clr | input | 1 | Clear trap flag |
| flags_q | output | 16 | Flag word |
| str_step | output | 16 | Signed string pointer step |

## Verification
The assertions assume that the result and carry inputs agree with the operands for the stated class and width. The block cannot check this, so the bench acts as the ALU: it builds `alu_res` and `alu_cout` from the operands on every drive, and its borrow is the unsigned compare of the masked operands. The assertions also assume `rst` is high from time zero so that no past value reaches back before reset. The bench raises reset before its first clock edge.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    localparam int CF_B = 0;
    localparam int PF_B = 2;
    localparam int AF_B = 4;
    localparam int ZF_B = 6;
    localparam int SF_B = 7;
    localparam int TF_B = 8;
    localparam int IF_B = 9;
    localparam int DF_B = 10;
    localparam int OF_B = 11;

    localparam logic [DATA_W-1:0] FIXED_ONES = 16'hF002;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_LOGX  = 2'd3
    } op_class_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } status_t;

    // control vector order: [2]=DF, [1]=IF, [0]=TF
    typedef logic [2:0] ctrl_t;

    function automatic logic [DATA_W-1:0] pack_word(status_t s, ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = FIXED_ONES;
        w[CF_B]  = s.cf_f;
        w[PF_B]  = s.pf_f;
        w[AF_B]  = s.af_f;
        w[ZF_B]  = s.zf_f;
        w[SF_B]  = s.sf_f;
        w[OF_B]  = s.of_f;
        w[TF_B]  = c[0];
        w[IF_B]  = c[1];
        w[DF_B]  = c[2];
        return w;
    endfunction
endpackage

// File: rtl/fg_status_calc.sv
module fg_status_calc
    import fg_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int BW = BYTE_W
) (
    input  op_class_e      op,
    input  logic           word,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   r,
    input  logic           cout,
    input  logic           af_prev,
    output status_t        nxt
);
    localparam int WMSB = W - 1;
    localparam int BMSB = BW - 1;

    logic a_top, b_top, r_top;
    logic zero_w, zero_b;
    logic add_ovf, sub_ovf;

    always_comb begin
        a_top   = word ? a[WMSB] : a[BMSB];
        b_top   = word ? b[WMSB] : b[BMSB];
        r_top   = word ? r[WMSB] : r[BMSB];
        zero_b  = (r[BMSB:0] == '0);
        zero_w  = (r == '0);
        add_ovf = (a_top == b_top) && (r_top != a_top);
        sub_ovf = (a_top != b_top) && (r_top != a_top);

        nxt.sf_f = r_top;
        nxt.zf_f = word ? zero_w : zero_b;
        nxt.pf_f = ~(^r[BMSB:0]);
        unique case (op)
            OPC_ADD: begin
                nxt.cf_f = cout;
                nxt.of_f = add_ovf;
                nxt.af_f = a[4] ^ b[4] ^ r[4];
            end
            OPC_SUB: begin
                nxt.cf_f = cout;
                nxt.of_f = sub_ovf;
                nxt.af_f = a[4] ^ b[4] ^ r[4];
            end
            default: begin
                nxt.cf_f = 1'b0;
                nxt.of_f = 1'b0;
                nxt.af_f = af_prev;
            end
        endcase
    end
endmodule

// File: rtl/fg_ctrl_bank.sv
module fg_ctrl_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_v[i])
                q[i] <= 1'b1;
            else if (clr_v[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/fg_step_gen.sv
module fg_step_gen #(
    parameter int STEP_W = 16
) (
    input  logic              dir_down,
    input  logic              word,
    output logic [STEP_W-1:0] step
);
    logic [STEP_W-1:0] mag;
    always_comb begin
        mag  = word ? STEP_W'(2) : STEP_W'(1);
        step = dir_down ? (~mag + STEP_W'(1)) : mag;
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import fg_pkg::*;
#(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [1:0]        op_class,
    input  logic              word_sel,
    input  logic [15:0]       opnd_a,
    input  logic [15:0]       opnd_b,
    input  logic [15:0]       alu_res,
    input  logic              alu_cout,
    input  logic              df_set,
    input  logic              df_clr,
    input  logic              if_set,
    input  logic              if_clr,
    input  logic              tf_set,
    input  logic              tf_clr,
    output logic [15:0]       flags_q,
    output logic [STEP_W-1:0] str_step
);
    status_t stat_q, stat_d;
    ctrl_t   ctrl_q;

    fg_status_calc u_calc (
        .op      (op_class_e'(op_class)),
        .word    (word_sel),
        .a       (opnd_a),
        .b       (opnd_b),
        .r       (alu_res),
        .cout    (alu_cout),
        .af_prev (stat_q.af_f),
        .nxt     (stat_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else if (upd_en)
            stat_q <= stat_d;
    end

    fg_ctrl_bank #(.N(3)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .set_v ({df_set, if_set, tf_set}),
        .clr_v ({df_clr, if_clr, tf_clr}),
        .q     (ctrl_q)
    );

    fg_step_gen #(.STEP_W(STEP_W)) u_step (
        .dir_down (ctrl_q[2]),
        .word     (word_sel),
        .step     (str_step)
    );

    assign flags_q = pack_word(stat_q, ctrl_q);
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_en,
    input logic [1:0]        op_class,
    input logic [15:0]       alu_res,
    input logic              df_set,
    input logic              df_clr,
    input logic              if_set,
    input logic              if_clr,
    input logic              tf_set,
    input logic              tf_clr,
    input logic [15:0]       flags_q,
    input logic [STEP_W-1:0] str_step
);
    logic any_strobe;
    assign any_strobe = df_set | df_clr | if_set | if_clr | tf_set | tf_clr;

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !any_strobe) |=> $stable(flags_q));

    assert_parity_low_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (flags_q[2] == ~(^$past(alu_res[7:0]))));

    assert_logic_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_class[1]) |=>
            (!flags_q[0] && !flags_q[11] && flags_q[4] == $past(flags_q[4])));

    assert_df_set_R10: assert property (@(posedge clk) disable iff (rst)
        df_set |=> flags_q[10]);

    assert_df_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (df_clr && !df_set) |=> !flags_q[10]);

    assert_step_dir_R11: assert property (@(posedge clk) disable iff (rst)
        str_step[STEP_W-1] == flags_q[10]);
endmodule

bind alu_flag_unit fg_checker #(.STEP_W(STEP_W)) u_fg_checker (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .op_class (op_class),
    .alu_res  (alu_res),
    .df_set   (df_set),
    .df_clr   (df_clr),
    .if_set   (if_set),
    .if_clr   (if_clr),
    .tf_set   (tf_set),
    .tf_clr   (tf_clr),
    .flags_q  (flags_q),
    .str_step (str_step)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_en = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        word_sel = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic        alu_cout = 1'b0;
    logic        df_set = 0, df_clr = 0, if_set = 0, if_clr = 0, tf_set = 0, tf_clr = 0;
    logic [15:0] flags_q;
    logic [15:0] str_step;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] fl;
        logic [15:0] st;
        string       tag;
    } item_t;
    item_t sb[$];

    // bench model state
    logic m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
    logic m_df = 0, m_if = 0, m_tf = 0;

    always #4 clk = ~clk;

    alu_flag_unit u0 (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class),
        .word_sel(word_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_res(alu_res), .alu_cout(alu_cout),
        .df_set(df_set), .df_clr(df_clr), .if_set(if_set), .if_clr(if_clr),
        .tf_set(tf_set), .tf_clr(tf_clr),
        .flags_q(flags_q), .str_step(str_step)
    );

    function automatic logic [15:0] model_word();
        logic [15:0] w;
        w = 16'hF002;   // R2 fixed bits
        w[0] = m_cf; w[2] = m_pf; w[4] = m_af; w[6] = m_zf; w[7] = m_sf;
        w[8] = m_tf; w[9] = m_if; w[10] = m_df; w[11] = m_of;
        return w;
    endfunction

    // set/clr order: [2]=DF [1]=IF [0]=TF
    task automatic go(input logic [1:0] op, input bit w, input logic [15:0] a,
                      input logic [15:0] b, input bit up, input logic [2:0] s,
                      input logic [2:0] c, input string tag);
        logic [16:0] full;
        logic [15:0] mask, r, am, bm;
        logic co;
        int msb;
        item_t it;
        @(negedge clk);
        mask = w ? 16'hFFFF : 16'h00FF;
        msb  = w ? 15 : 7;
        am = a & mask; bm = b & mask;
        if (op == 2'd0) begin
            full = {1'b0, am} + {1'b0, bm};
            r  = full[15:0] & mask;
            co = w ? full[16] : full[8];
        end else if (op == 2'd1) begin
            r  = (am - bm) & mask;
            co = (am < bm);
        end else begin
            r  = a & b;
            co = 1'b1;      // must be ignored for logic (R9)
        end
        opnd_a = a; opnd_b = b; alu_res = r; alu_cout = co;
        op_class = op; word_sel = w; upd_en = up;
        {df_set, if_set, tf_set} = s;
        {df_clr, if_clr, tf_clr} = c;
        if (up) begin
            m_sf = r[msb];
            m_zf = ((r & mask) == 0);
            m_pf = ~(^r[7:0]);
            if (op[1]) begin
                m_cf = 0; m_of = 0;
            end else begin
                m_cf = co;
                m_af = a[4] ^ b[4] ^ r[4];
                if (op == 2'd0) m_of = (a[msb] == b[msb]) && (r[msb] != a[msb]);
                else            m_of = (a[msb] != b[msb]) && (r[msb] != a[msb]);
            end
        end
        if (s[2]) m_df = 1; else if (c[2]) m_df = 0;
        if (s[1]) m_if = 1; else if (c[1]) m_if = 0;
        if (s[0]) m_tf = 1; else if (c[0]) m_tf = 0;
        it.fl  = model_word();
        it.st  = m_df ? (w ? 16'hFFFE : 16'hFFFF) : (w ? 16'd2 : 16'd1);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_run++;
                if (flags_q !== it.fl) begin
                    n_fail++;
                    $display("FAIL %s flags got %h exp %h", it.tag, flags_q, it.fl);
                end
                n_run++;
                if (str_step !== it.st) begin
                    n_fail++;
                    $display("FAIL %s/R11 step got %h exp %h", it.tag, str_step, it.st);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        n_run++;   // R1 reset state, R2 fixed bits
        if (flags_q !== 16'hF002) begin
            n_fail++;
            $display("FAIL R1 reset flags got %h exp %h", flags_q, 16'hF002);
        end
        n_run++;
        if (str_step !== 16'd1) begin
            n_fail++;
            $display("FAIL R11 reset step got %h exp %h", str_step, 16'd1);
        end
        // R4 R6 R8 byte add with half carry and signed overflow
        go(2'd0, 0, 16'h007F, 16'h0001, 1, 3'b000, 3'b000, "R8_byte_add_ovf");
        // R7 byte add with carry out, zero result
        go(2'd0, 0, 16'h12FF, 16'h3401, 1, 3'b000, 3'b000, "R7_byte_carry_zero");
        // R8 word add overflow
        go(2'd0, 1, 16'h7FFF, 16'h0001, 1, 3'b000, 3'b000, "R8_word_add_ovf");
        // R6 R7 byte subtract with borrow
        go(2'd1, 0, 16'h0000, 16'h0001, 1, 3'b000, 3'b000, "R6_byte_sub_borrow");
        // R8 byte subtract overflow 0x80-0x01
        go(2'd1, 0, 16'h0080, 16'h0001, 1, 3'b000, 3'b000, "R8_byte_sub_ovf");
        // R4 word subtract to zero
        go(2'd1, 1, 16'h1234, 16'h1234, 1, 3'b000, 3'b000, "R4_word_zero");
        // R5 word result 0x0100: low byte zero, parity even, ZF clear
        go(2'd0, 1, 16'h00FF, 16'h0001, 1, 3'b000, 3'b000, "R5_word_low_parity");
        // set AF first, then logic must keep it (R9)
        go(2'd0, 0, 16'h000F, 16'h0001, 1, 3'b000, 3'b000, "R6_af_set");
        go(2'd2, 1, 16'hF0F0, 16'h8F01, 1, 3'b000, 3'b000, "R9_logic_keep_af");
        go(2'd3, 0, 16'h00FF, 16'h0000, 1, 3'b000, 3'b000, "R9_logic_alt");
        // R3 hold: no update, operands change
        go(2'd0, 1, 16'h7FFF, 16'h7FFF, 0, 3'b000, 3'b000, "R3_hold_1");
        go(2'd1, 0, 16'h0000, 16'h00FF, 0, 3'b000, 3'b000, "R3_hold_2");
        // R10 control flags and R11 step
        go(2'd0, 0, 16'h0000, 16'h0000, 0, 3'b100, 3'b000, "R10_df_set_byte");
        go(2'd0, 1, 16'h0000, 16'h0000, 0, 3'b000, 3'b000, "R11_down_word");
        go(2'd0, 0, 16'h0001, 16'h0001, 1, 3'b011, 3'b000, "R10_if_tf_with_update");
        go(2'd0, 1, 16'h0000, 16'h0000, 0, 3'b110, 3'b111, "R10_both_set_wins");
        go(2'd1, 1, 16'h8000, 16'h0001, 1, 3'b000, 3'b101, "R10_clear_df_tf");
        go(2'd0, 1, 16'h0000, 16'h0000, 0, 3'b000, 3'b010, "R11_up_word");
        go(2'd0, 0, 16'h0000, 16'h0000, 0, 3'b000, 3'b000, "R11_up_byte");
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule